// File: doc/BRIEF.md
# Network Controller Indirect Register Front End

This block is the host-facing register front end of a network controller. The host reaches it through three byte offsets on a simple single-cycle bus. The first offset is a register pointer port. The second is a data port that reads or writes the register the pointer selects. The third is a configuration data port. Behind the pointer sit four registers: the main control/status register, an interrupt-mask register, a mode register and a ring-length register.

From these registers the block drives the interrupt line and the receive and transmit run enables. It also reports the receive and transmit ring sizes. A host write of the INIT control bit produces a one-cycle request to fetch the initialization block. A host write of STOP produces a one-cycle pulse that rewinds the ring positions.

The memory fetch is done elsewhere. When it finishes, that logic returns a completion strobe together with the decoded mode and ring-length fields. Receive, transmit and error events arrive as single-cycle strobes and latch into the status register, where the host clears them by writing ones.

Top module: `nic_reg_front`

## Requirements
- R1: After reset the pointer reads 0, the status register reads 0x0004 (only STOP set), the mask, mode and ring-length registers read 0, irq, rx_on, tx_on, init_req and ring_rewind are low, and both ring sizes are 1.
- R2: A write at byte offset 0x14 loads the pointer with bits 7:0 of the write data. A read at 0x14 returns the pointer zero-extended.
- R3: A status write (index 0 at offset 0x10) with bit 2 set leaves the status register reading exactly 0x0004, whatever other bits are written and whatever event strobes arrive in the same cycle. ring_rewind is high for the one cycle after that write, and init_req stays low.
- R4: In the status register, bits 14, 13, 12, 11, 10, 9 and 8 clear when written with 1. Writing 0 to them leaves them unchanged.
- R5: rx_event sets status bit 10, tx_event sets bit 9, and err_event[3:0] sets bits 14:11 (err_event[0] drives bit 11). An event set wins over a host clear of the same bit in the same cycle.
- R6: Status bit 15 reads as the OR of bits 14:11. Status bit 3 always reads 0.
- R7: A status write with bit 0 set (and bit 2 clear) sets the INIT bit (0), clears STOP, and raises init_req for one cycle after the write. A fetch_done strobe sets the init-done bit (8) and loads the mode register from fetch_mode and the receive and transmit ring log2 lengths from fetch_rx_log2 and fetch_tx_log2.
- R8: A status write with bit 1 set sets START (bit 1) and clears STOP. RX-on (bit 5, port rx_on) is START with mode bit 0 clear. TX-on (bit 4, port tx_on) is START with mode bit 1 clear. The mode register is index 15 and stores 16 bits.
- R9: The interrupt flag (status bit 7) is set when any status bit in 14:8 is set and the mask register (index 3) bit at the same position is clear. irq is high when both the flag and bit 6 are set.
- R10: The ring-length register (index 6) holds the receive log2 length in bits 11:8 and the transmit log2 length in bits 15:12, and reads back with all other bits zero. Each ring size is 2^n, capped at 512.
- R11: Indexes other than 0, 3, 6 and 15 read 0, and writes to them change nothing. The mask register keeps only bits 14:8. The configuration port at offset 0x1C reads 0, and writes to it change nothing.
- R12: Status bit 6 (interrupt enable) takes the value written to it on every status write that does not have bit 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| rx_event | input | 1 | Receive-complete strobe |
| tx_event | input | 1 | Transmit-complete strobe |
| err_event | input | 4 | Error strobes for status bits 14:11 |
| fetch_done | input | 1 | Initialization block fetch completed |
| fetch_mode | input | 16 | Mode value decoded from the fetched block |
| fetch_rx_log2 | input | 4 | Receive ring log2 length from the fetched block |
| fetch_tx_log2 | input | 4 | Transmit ring log2 length from the fetched block |
| irq | output | 1 | Interrupt request |
| rx_on | output | 1 | Receive path enabled |
| tx_on | output | 1 | Transmit path enabled |
| rx_ring_size | output | 10 | Receive ring entry count |
| tx_ring_size | output | 10 | Transmit ring entry count |
| init_req | output | 1 | One-cycle request to fetch the initialization block |
| ring_rewind | output | 1 | One-cycle pulse to reset ring positions |

## Verification
The ring-length register is swept over all 256 pairs of receive and transmit codes. This covers the values below the cap, the exact cap code and every code above it, and it would expose crossed lanes or a wrong bit slice. The interrupt logic is swept over each of the seven event bits, with its mask bit on and off and the enable on and off. This shows whether each source reaches the flag, whether the mask lines up bit for bit, and whether the enable gates only the pin. All four combinations of the mode disable bits are tried under START, which separates the receive enable from the transmit enable. Directed collisions check priority: an event against a host clear of the same bit, and an event against STOP.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int REG_W  = 16;
    localparam int IDX_W  = 8;

    // Byte offsets of the three host ports
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_PTR  = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h1C;

    // Register indexes behind the pointer
    localparam logic [IDX_W-1:0] IDX_STATUS = 8'd0;
    localparam logic [IDX_W-1:0] IDX_MASK   = 8'd3;
    localparam logic [IDX_W-1:0] IDX_RING   = 8'd6;
    localparam logic [IDX_W-1:0] IDX_MODE   = 8'd15;

    // Control bit positions in a status write
    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_STOP  = 2;
    localparam int B_IEN   = 6;

    // Mode register disable bits
    localparam int B_DIS_RX = 0;
    localparam int B_DIS_TX = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_RING,
        SEL_MODE
    } reg_sel_e;

    // Stored state of the status register (derived bits excluded)
    typedef struct packed {
        logic [3:0] err;    // bits 14:11
        logic       rint;   // bit 10
        logic       tint;   // bit 9
        logic       idone;  // bit 8
        logic       ien;    // bit 6
        logic       start;  // bit 1
        logic       stop;   // bit 0..2 group
        logic       init;
    } ctl_state_t;

    localparam ctl_state_t CTL_STOPPED = '{
        err: 4'h0, rint: 1'b0, tint: 1'b0, idone: 1'b0,
        ien: 1'b0, start: 1'b0, stop: 1'b1, init: 1'b0
    };

    function automatic reg_sel_e index_to_sel(input logic [IDX_W-1:0] idx);
        reg_sel_e s;
        case (idx)
            IDX_STATUS: s = SEL_STATUS;
            IDX_MASK:   s = SEL_MASK;
            IDX_RING:   s = SEL_RING;
            IDX_MODE:   s = SEL_MODE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Event group, bits 14:8 of the status register, as a 7-bit vector
    function automatic logic [6:0] event_bits(input ctl_state_t s);
        return {s.err, s.rint, s.tint, s.idone};
    endfunction

    function automatic logic [REG_W-1:0] pack_status(
        input ctl_state_t s,
        input logic       flag,
        input logic       rxo,
        input logic       txo
    );
        return {(|s.err), s.err, s.rint, s.tint, s.idone, flag, s.ien,
                rxo, txo, 1'b0, s.stop, s.start, s.init};
    endfunction

endpackage

// File: rtl/nic_reg_decode.sv
module nic_reg_decode
    import nic_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [IDX_W-1:0]     wdata_lo,
    output logic [IDX_W-1:0]     ptr,
    output reg_sel_e             sel,
    output logic                 data_wr,
    output logic                 data_rd,
    output logic                 ptr_rd
);

    logic [IDX_W-1:0] ptr_q;
    logic             ptr_wr;

    assign ptr_wr  = bus_sel &&  bus_wr && (bus_addr == OFS_PTR);
    assign ptr_rd  = bus_sel && !bus_wr && (bus_addr == OFS_PTR);
    assign data_wr = bus_sel &&  bus_wr && (bus_addr == OFS_DATA);
    assign data_rd = bus_sel && !bus_wr && (bus_addr == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (ptr_wr) ptr_q <= wdata_lo;
    end

    assign ptr = ptr_q;
    assign sel = index_to_sel(ptr_q);

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ptr_wr |=> (ptr == $past(wdata_lo)));  // R2

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ptr_wr |=> $stable(ptr));  // R2

endmodule

// File: rtl/nic_status_unit.sv
module nic_status_unit
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rx_event,
    input  logic              tx_event,
    input  logic [3:0]        err_event,
    input  logic              fetch_done,
    input  logic              dis_rx,
    input  logic              dis_tx,
    input  logic [6:0]        mask,
    output logic [REG_W-1:0]  status_word,
    output logic              irq,
    output logic              rx_on,
    output logic              tx_on,
    output logic              init_req,
    output logic              ring_rewind
);

    ctl_state_t st_q, st_d;
    logic       stop_wr;
    logic       init_wr;
    logic       flag;
    logic       init_req_q;
    logic       rewind_q;

    assign stop_wr = wr && wdata[B_STOP];
    assign init_wr = wr && !wdata[B_STOP] && wdata[B_INIT];

    always_comb begin
        st_d = st_q;
        if (stop_wr) begin
            st_d = CTL_STOPPED;
        end else begin
            if (wr) begin
                st_d.err   = st_d.err & ~wdata[14:11];
                st_d.rint  = st_d.rint  & ~wdata[10];
                st_d.tint  = st_d.tint  & ~wdata[9];
                st_d.idone = st_d.idone & ~wdata[8];
                st_d.ien   = wdata[B_IEN];
                if (wdata[B_INIT]) begin
                    st_d.init = 1'b1;
                    st_d.stop = 1'b0;
                end
                if (wdata[B_START]) begin
                    st_d.start = 1'b1;
                    st_d.stop  = 1'b0;
                end
            end
            // Event sets are applied after the clears so they win
            st_d.err   = st_d.err | err_event;
            st_d.rint  = st_d.rint  | rx_event;
            st_d.tint  = st_d.tint  | tx_event;
            st_d.idone = st_d.idone | fetch_done;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= CTL_STOPPED;
            init_req_q <= 1'b0;
            rewind_q   <= 1'b0;
        end else begin
            st_q       <= st_d;
            init_req_q <= init_wr;
            rewind_q   <= stop_wr;
        end
    end

    assign flag        = |(event_bits(st_q) & ~mask);
    assign irq         = flag && st_q.ien;
    assign rx_on       = st_q.start && !dis_rx;
    assign tx_on       = st_q.start && !dis_tx;
    assign init_req    = init_req_q;
    assign ring_rewind = rewind_q;
    assign status_word = pack_status(st_q, flag, rx_on, tx_on);

    AST_STOP_ONLY: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> (status_word == 16'h0004));  // R3

    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (rx_event && !stop_wr) |=> st_q.rint);  // R5

    AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (tx_event && !stop_wr) |=> st_q.tint);  // R5

    AST_FETCH_IDONE: assert property (@(posedge clk) disable iff (rst)
        (fetch_done && !stop_wr) |=> st_q.idone);  // R7

    AST_INIT_REQ_STATE: assert property (@(posedge clk) disable iff (rst)
        init_req |-> (st_q.init && !st_q.stop && !ring_rewind));  // R7

    AST_RUN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(st_q.start && st_q.stop));  // R8

endmodule

// File: rtl/nic_ring_cfg.sv
module nic_ring_cfg
    import nic_regs_pkg::*;
#(
    parameter int MAX_RING_LOG2 = 9,
    parameter int RING_W        = MAX_RING_LOG2 + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [7:0]        wdata_hi,
    input  logic              fetch_done,
    input  logic [3:0]        fetch_rx_log2,
    input  logic [3:0]        fetch_tx_log2,
    output logic [REG_W-1:0]  ring_word,
    output logic [RING_W-1:0] rx_size,
    output logic [RING_W-1:0] tx_size
);

    localparam int         LANES = 2;
    localparam logic [3:0] MAX_L = 4'(MAX_RING_LOG2);

    logic [LANES-1:0][3:0]        l2_q;
    logic [LANES-1:0][RING_W-1:0] size;
    logic [LANES*4-1:0]           fetch_l2;

    assign fetch_l2 = {fetch_tx_log2, fetch_rx_log2};

    // Lane 0 is receive (bits 11:8), lane 1 is transmit (bits 15:12)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [3:0] eff;

        always_ff @(posedge clk) begin
            if (rst)             l2_q[g] <= '0;
            else if (fetch_done) l2_q[g] <= fetch_l2[4*g +: 4];
            else if (wr)         l2_q[g] <= wdata_hi[4*g +: 4];
        end

        assign eff     = (l2_q[g] > MAX_L) ? MAX_L : l2_q[g];
        assign size[g] = RING_W'(1) << eff;
    end

    assign rx_size   = size[0];
    assign tx_size   = size[1];
    assign ring_word = {l2_q[1], l2_q[0], 8'h00};

    AST_RING_POW2: assert property (@(posedge clk) disable iff (rst)
        ($countones(rx_size) == 1) && ($countones(tx_size) == 1));  // R10

    AST_RING_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr && !fetch_done) |=> $stable(ring_word));  // R10

endmodule

// File: rtl/nic_reg_front.sv
module nic_reg_front
    import nic_regs_pkg::*;
#(
    parameter  int MAX_RING_LOG2 = 9,
    localparam int RING_W        = MAX_RING_LOG2 + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_event,
    input  logic              tx_event,
    input  logic [3:0]        err_event,
    input  logic              fetch_done,
    input  logic [15:0]       fetch_mode,
    input  logic [3:0]        fetch_rx_log2,
    input  logic [3:0]        fetch_tx_log2,
    output logic              irq,
    output logic              rx_on,
    output logic              tx_on,
    output logic [RING_W-1:0] rx_ring_size,
    output logic [RING_W-1:0] tx_ring_size,
    output logic              init_req,
    output logic              ring_rewind
);

    logic [IDX_W-1:0] ptr;
    reg_sel_e         sel;
    logic             data_wr, data_rd, ptr_rd;
    logic             cfg_rd;
    logic [REG_W-1:0] status_word, ring_word;
    logic [REG_W-1:0] mode_q;
    logic [6:0]       mask_q;
    logic [REG_W-1:0] wd;
    logic [REG_W-1:0] sel_word;
    logic             unused_bits;

    assign wd          = bus_wdata[REG_W-1:0];
    assign unused_bits = ^{bus_wdata[31:16], wd[15], wd[7:0]};
    assign cfg_rd      = bus_sel && !bus_wr && (bus_addr == OFS_CFG);

    nic_reg_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wdata_lo (bus_wdata[IDX_W-1:0]),
        .ptr      (ptr),
        .sel      (sel),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .ptr_rd   (ptr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= '0;
        end else begin
            if (fetch_done)                       mode_q <= fetch_mode;
            else if (data_wr && sel == SEL_MODE)  mode_q <= wd;
            if (data_wr && sel == SEL_MASK)       mask_q <= wd[14:8];
        end
    end

    nic_status_unit u_status (
        .clk         (clk),
        .rst         (rst),
        .wr          (data_wr && sel == SEL_STATUS),
        .wdata       (wd),
        .rx_event    (rx_event),
        .tx_event    (tx_event),
        .err_event   (err_event),
        .fetch_done  (fetch_done),
        .dis_rx      (mode_q[B_DIS_RX]),
        .dis_tx      (mode_q[B_DIS_TX]),
        .mask        (mask_q),
        .status_word (status_word),
        .irq         (irq),
        .rx_on       (rx_on),
        .tx_on       (tx_on),
        .init_req    (init_req),
        .ring_rewind (ring_rewind)
    );

    nic_ring_cfg #(
        .MAX_RING_LOG2 (MAX_RING_LOG2),
        .RING_W        (RING_W)
    ) u_ring (
        .clk           (clk),
        .rst           (rst),
        .wr            (data_wr && sel == SEL_RING),
        .wdata_hi      (wd[15:8]),
        .fetch_done    (fetch_done),
        .fetch_rx_log2 (fetch_rx_log2),
        .fetch_tx_log2 (fetch_tx_log2),
        .ring_word     (ring_word),
        .rx_size       (rx_ring_size),
        .tx_size       (tx_ring_size)
    );

    always_comb begin
        case (sel)
            SEL_STATUS: sel_word = status_word;
            SEL_MASK:   sel_word = {1'b0, mask_q, 8'h00};
            SEL_RING:   sel_word = ring_word;
            SEL_MODE:   sel_word = mode_q;
            default:    sel_word = '0;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        if (ptr_rd)       bus_rdata = {24'h0, ptr};
        else if (data_rd) bus_rdata = {16'h0, sel_word};
        else if (cfg_rd)  bus_rdata = '0;
    end

    AST_RUN_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (rst)
        (rx_on && $stable(mode_q)) |-> !mode_q[B_DIS_RX]);  // R8

    AST_IRQ_QUIET_STOPPED: assert property (@(posedge clk) disable iff (rst)
        ring_rewind |-> (!irq && !rx_on && !tx_on));  // R3

endmodule

// File: tb/tb_nic_reg_front.sv
module tb_nic_reg_front;

    localparam logic [4:0] A_DATA = 5'h10;
    localparam logic [4:0] A_PTR  = 5'h14;
    localparam logic [4:0] A_CFG  = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_event = 1'b0, tx_event = 1'b0;
    logic [3:0]  err_event = '0;
    logic        fetch_done = 1'b0;
    logic [15:0] fetch_mode = '0;
    logic [3:0]  fetch_rx_log2 = '0, fetch_tx_log2 = '0;
    logic        irq, rx_on, tx_on, init_req, ring_rewind;
    logic [9:0]  rx_ring_size, tx_ring_size;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nic_reg_front dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_event(rx_event), .tx_event(tx_event), .err_event(err_event),
        .fetch_done(fetch_done), .fetch_mode(fetch_mode),
        .fetch_rx_log2(fetch_rx_log2), .fetch_tx_log2(fetch_tx_log2),
        .irq(irq), .rx_on(rx_on), .tx_on(tx_on),
        .rx_ring_size(rx_ring_size), .tx_ring_size(tx_ring_size),
        .init_req(init_req), .ring_rewind(ring_rewind)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic csr_write(input int idx, input logic [31:0] d);
        bus_write(A_PTR, 32'(idx));
        bus_write(A_DATA, d);
    endtask

    task automatic csr_read(input int idx, output logic [31:0] d);
        bus_write(A_PTR, 32'(idx));
        bus_read(A_DATA, d);
    endtask

    // b: 0 idone (fetch_done), 1 tint, 2 rint, 3..6 err_event[b-3]
    task automatic pulse_event(input int b);
        @(negedge clk);
        case (b)
            0: fetch_done = 1'b1;
            1: tx_event = 1'b1;
            2: rx_event = 1'b1;
            default: err_event = 4'(1 << (b - 3));
        endcase
        @(negedge clk);
        fetch_done = 1'b0; tx_event = 1'b0; rx_event = 1'b0; err_event = '0;
    endtask

    function automatic logic [9:0] exp_size(input int n);
        return (n > 9) ? 10'd512 : 10'(1 << n);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(A_PTR, rd);  check("R1 ptr", rd, 0);
        bus_read(A_DATA, rd); check("R1 status", rd, 32'h0004);
        csr_read(3, rd);      check("R1 mask", rd, 0);
        csr_read(6, rd);      check("R1 ring", rd, 0);
        csr_read(15, rd);     check("R1 mode", rd, 0);
        check("R1 irq/on/pulses", {irq, rx_on, tx_on, init_req, ring_rewind}, 0);
        check("R1 sizes", {rx_ring_size, tx_ring_size}, {10'd1, 10'd1});

        // R2 pointer
        bus_write(A_PTR, 32'h0000_01A5);
        bus_read(A_PTR, rd); check("R2 ptr low byte", rd, 32'h0000_00A5);

        // R11 unused index, config port, mask width
        csr_write(5, 32'hFFFF);
        bus_read(A_DATA, rd); check("R11 unused index read", rd, 0);
        csr_read(0, rd);      check("R11 status untouched", rd, 32'h0004);
        bus_write(A_CFG, 32'hFFFF_FFFF);
        bus_read(A_CFG, rd);  check("R11 cfg port read", rd, 0);
        csr_read(0, rd);      check("R11 status after cfg write", rd, 32'h0004);
        csr_read(15, rd);     check("R11 mode after cfg write", rd, 0);
        csr_write(3, 32'hFFFF);
        bus_read(A_DATA, rd); check("R11 mask keeps 14:8", rd, 32'h7F00);
        csr_write(3, 0);

        // R8 run enables against mode disable bits, R3 stop
        for (int m = 0; m < 4; m++) begin
            csr_write(15, 32'(m));
            bus_read(A_DATA, rd); check("R8 mode readback", rd, 32'(m));
            csr_write(0, 32'h0002);
            check("R8 rx_on", 32'(rx_on), 32'(~m & 1));
            check("R8 tx_on", 32'(tx_on), 32'((~m >> 1) & 1));
            bus_read(A_DATA, rd);
            check("R8 status", rd, 32'h0002 | 32'((~m & 1) << 5) | 32'(((~m >> 1) & 1) << 4));
            csr_write(0, 32'h0004);
            check("R3 rewind pulse", 32'(ring_rewind), 1);
            check("R3 run off", {30'h0, rx_on, tx_on}, 0);
        end
        csr_write(15, 0);

        // R3 stop beats init and start
        csr_write(0, 32'h0007);
        check("R3 no init_req", 32'(init_req), 0);
        check("R3 rewind", 32'(ring_rewind), 1);
        bus_read(A_DATA, rd); check("R3 stop only", rd, 32'h0004);

        // R7 init and fetch completion
        csr_write(0, 32'h0001);
        check("R7 init_req pulse", 32'(init_req), 1);
        @(negedge clk);
        check("R7 init_req single", 32'(init_req), 0);
        bus_read(A_DATA, rd); check("R7 init set stop clear", rd, 32'h0001);
        fetch_mode = 16'h0002; fetch_rx_log2 = 4'd3; fetch_tx_log2 = 4'd12;
        pulse_event(0);
        fetch_mode = '0; fetch_rx_log2 = '0; fetch_tx_log2 = '0;
        bus_read(A_DATA, rd); check("R7 init done and flag", rd, 32'h0181);
        csr_read(15, rd); check("R7 mode loaded", rd, 32'h0002);
        csr_read(6, rd);  check("R7 ring loaded", rd, 32'hC300);
        check("R7 sizes", {rx_ring_size, tx_ring_size}, {10'd8, 10'd512});
        csr_write(0, 32'h0002);
        check("R8 rx only", {30'h0, rx_on, tx_on}, 32'h2);
        bus_read(A_DATA, rd); check("R8 status after start", rd, 32'h01A3);

        // R4 / R6 write-one-to-clear and summary bit
        bus_write(A_DATA, 32'h0100);
        bus_read(A_DATA, rd); check("R4 clear init done", rd, 32'h0023);
        pulse_event(3); pulse_event(4); pulse_event(5); pulse_event(6);
        bus_read(A_DATA, rd); check("R6 summary set", rd, 32'hF8A3);
        bus_write(A_DATA, 32'h0000);
        bus_read(A_DATA, rd); check("R4 zero write keeps", rd, 32'hF8A3);
        bus_write(A_DATA, 32'h2000);
        bus_read(A_DATA, rd); check("R4 clear bit 13", rd, 32'hD8A3);
        bus_write(A_DATA, 32'h5800);
        bus_read(A_DATA, rd); check("R6 summary clear", rd, 32'h0023);
        bus_write(A_DATA, 32'h0008);
        bus_read(A_DATA, rd); check("R6 bit3 reads zero", rd, 32'h0023);

        // R5 event set wins over clear
        pulse_event(2);
        bus_read(A_DATA, rd); check("R5 rx event", rd, 32'h04A3);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = 32'h0400; rx_event = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_event = 1'b0;
        bus_read(A_DATA, rd); check("R5 set wins", rd, 32'h04A3);
        bus_write(A_DATA, 32'h0400);
        bus_read(A_DATA, rd); check("R4 rint clear", rd, 32'h0023);
        pulse_event(1);
        bus_read(A_DATA, rd); check("R5 tx event", rd, 32'h02A3);
        bus_write(A_DATA, 32'h0200);
        bus_read(A_DATA, rd); check("R4 tint clear", rd, 32'h0023);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = 32'h0004; rx_event = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_event = 1'b0;
        bus_read(A_DATA, rd); check("R3 stop beats event", rd, 32'h0004);
        csr_write(15, 0);

        // R9 / R12 interrupt sweep
        for (int b = 0; b < 7; b++) begin
            for (int m = 0; m < 2; m++) begin
                for (int e = 0; e < 2; e++) begin
                    csr_write(3, (m != 0) ? 32'(1 << (8 + b)) : 32'h0);
                    csr_write(0, 32'h7F00 | 32'(e << 6));
                    pulse_event(b);
                    bus_read(A_DATA, rd);
                    check("R9 flag", 32'(rd[7]), 32'(m == 0));
                    check("R12 enable bit", 32'(rd[6]), 32'(e));
                    check("R9 irq pin", 32'(irq), 32'((m == 0) && (e != 0)));
                end
            end
        end
        csr_write(3, 0);
        csr_write(0, 32'h7F00);

        // R10 ring length sweep
        for (int r = 0; r < 16; r++) begin
            for (int t = 0; t < 16; t++) begin
                csr_write(6, 32'((t << 12) | (r << 8) | 8'hFF));
                check("R10 rx size", 32'(rx_ring_size), 32'(exp_size(r)));
                check("R10 tx size", 32'(tx_ring_size), 32'(exp_size(t)));
                bus_read(A_DATA, rd);
                check("R10 readback", rd, 32'((t << 12) | (r << 8)));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule